// File: doc/BRIEF.md
# Serial Memory Slave Command Engine

This block is the command front end of a byte-addressed serial SRAM. A host on the SPI pins selects it with an active-low chip select. The engine then shifts in an opcode byte, collects a 2- or 3-byte address (upper byte first) and either streams data bytes into a synchronous single-port array or streams array contents back out. The array address steps by one per byte and wraps from the top of the array to zero. It also serves the status-register commands. The write-enable latch and the status register live in a neighbouring protection block. This engine reads the latch state and the status byte as inputs and sends that block single-cycle set, clear and write pulses.

The SPI pins pass through synchronizers into the system clock domain, so SCK must run at no more than a quarter of the system clock. Clock-idle-low (mode 0) and clock-idle-high (mode 3) hosts are both accepted. The engine records the SCK level when chip select falls. In mode 3 it discards the falling edge that comes before the first bit. A low level on the hold pin freezes the transfer in place.

Top module: `spi_mem_slave`

## Requirements
- R1: Both SCK idle levels are accepted. In each, SI is captured on SCK rising edges and SO is launched on SCK falling edges, most significant bit first. In idle-high operation, the falling edge that comes before the first rising edge of a selection is not treated as a byte boundary.
- R2: Opcode 0x02 with the write-enable input high takes ADDR_BYTES address bytes, upper byte first, and keeps the low ADDR_W bits. Each following complete byte is written to the array at the current address.
- R3: During a read or write burst the address steps by one per byte and wraps from 2**ADDR_W-1 to 0.
- R4: Opcode 0x02 with the write-enable input low causes no array write for the rest of that selection. The next selection decodes a new opcode normally.
- R5: Opcode 0x03 returns array data on SO from the byte after the address. Opcode 0x0B returns it from the second byte after the address; the byte in between is a dummy.
- R6: Opcode 0x05 returns the status input byte on every following byte. Opcode 0x09 does the same after one dummy byte.
- R7: Opcode 0x06 pulses set_wen and opcode 0x04 pulses clr_wen. Opcode 0x01 with write-enable high pulses sr_we with the next byte on sr_wdata; with write-enable low it does nothing. At the end of a selection in which 0x01 or 0x02 was accepted, clr_wen pulses. The set_wen, clr_wen and sr_we pulses are each one cycle long and never coincide.
- R8: When chip select rises, so_oe drops within three system cycles, and a partly shifted byte is discarded.
- R9: While hold_n is low, SCK edges are ignored. The transfer resumes with its state intact when hold_n returns high.
- R10: An opcode that is not listed makes the engine ignore the rest of the selection: no array access and SO not enabled.
- R11: After reset, so_oe, mem_en and the control pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for the SO pad driver |
| wen_i | input | 1 | Write-enable latch state from the protection block |
| status_i | input | 8 | Status byte returned by status reads |
| set_wen | output | 1 | One-cycle pulse: set write-enable latch |
| clr_wen | output | 1 | One-cycle pulse: clear write-enable latch |
| sr_we | output | 1 | One-cycle pulse: write status register |
| sr_wdata | output | 8 | Status register write data |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write when high, read when low |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one cycle after a read strobe |

## Verification
Each pin change reaches the logic through a two-stage synchronizer. A byte's array write or read strobe therefore appears in the third system cycle after the SCK rising edge that completes the byte. The SO bit changes in the third cycle after the falling edge. The status pulses follow one cycle later. The bench holds each SCK phase for five system cycles, samples SO just before the next rising edge, and waits several cycles after raising chip select before it inspects the array model, the status model and so_oe, so every result is read after it is due. Sweeps write and read the whole small array in both idle levels, across the wrap point.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OPC_RD      = 8'h03;
    localparam logic [7:0] OPC_RD_FAST = 8'h0B;
    localparam logic [7:0] OPC_WR      = 8'h02;
    localparam logic [7:0] OPC_WEN_SET = 8'h06;
    localparam logic [7:0] OPC_WEN_CLR = 8'h04;
    localparam logic [7:0] OPC_SR_RD   = 8'h05;
    localparam logic [7:0] OPC_SR_FAST = 8'h09;
    localparam logic [7:0] OPC_SR_WR   = 8'h01;

    typedef enum logic [3:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DUMMY_MEM,
        PH_DUMMY_SR,
        PH_MEM_OUT,
        PH_MEM_IN,
        PH_SR_OUT,
        PH_SR_IN,
        PH_DISCARD
    } phase_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic sel,
    output logic si_s,
    output logic sck_lvl,
    output logic hold_ok,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise
);
    localparam logic [3:0] PIN_RST = 4'b1001; // {cs, sck, si, hold}

    typedef struct packed {
        logic [STAGES-1:0][3:0] pipe;
        logic                   cs_prev;
        logic                   sck_prev;
    } sync_t;

    sync_t s_q, s_d;
    logic [3:0] pins_s;

    assign pins_s  = s_q.pipe[STAGES-1];
    assign sel     = ~pins_s[3];
    assign sck_lvl = pins_s[2];
    assign si_s    = pins_s[1];
    assign hold_ok = pins_s[0];

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = {cs_n, sck, si, hold_n};
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.cs_prev  = pins_s[3];
        s_d.sck_prev = pins_s[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pipe     <= {STAGES{PIN_RST}};
            s_q.cs_prev  <= 1'b1;
            s_q.sck_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sck_rise = sel & hold_ok &  pins_s[2] & ~s_q.sck_prev;
    assign sck_fall = sel & hold_ok & ~pins_s[2] &  s_q.sck_prev;
    assign cs_fall  = ~pins_s[3] &  s_q.cs_prev;
    assign cs_rise  =  pins_s[3] & ~s_q.cs_prev;
endmodule

// File: rtl/spi_mem_bytes.sv
module spi_mem_bytes (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       sck_lvl,
    input  logic       rise,
    input  logic       fall,
    input  logic       si_s,
    input  logic       load_en,
    input  logic [7:0] load_val,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       boundary,
    output logic       so_bit
);
    typedef struct packed {
        logic [2:0] bit_cnt;
        logic [6:0] rx;
        logic [7:0] tx;
        logic       skip;
    } shf_t;

    shf_t b_q, b_d;

    assign boundary  = fall & (b_q.bit_cnt == 3'd0) & ~b_q.skip;
    assign byte_done = rise & (b_q.bit_cnt == 3'd7);
    assign byte_val  = {b_q.rx, si_s};
    assign so_bit    = b_q.tx[7];

    always_comb begin
        b_d = b_q;
        if (start) begin
            b_d.bit_cnt = 3'd0;
            b_d.rx      = '0;
            b_d.tx      = '0;
            b_d.skip    = sck_lvl;
        end else begin
            if (rise) begin
                b_d.bit_cnt = b_q.bit_cnt + 3'd1;
                b_d.rx      = {b_q.rx[5:0], si_s};
            end
            if (fall) begin
                if (b_q.skip) begin
                    b_d.skip = 1'b0;
                end else if (boundary && load_en) begin
                    b_d.tx = load_val;
                end else begin
                    b_d.tx = {b_q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    input  logic              boundary,
    input  logic              wen_i,
    input  logic [7:0]        status_i,
    input  logic [7:0]        mem_rdata,
    output logic              load_en,
    output logic [7:0]        load_val,
    output logic              drive,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              set_wen,
    output logic              clr_wen,
    output logic              sr_we,
    output logic [7:0]        sr_wdata
);
    localparam int               ACNT_W = $clog2(ADDR_BYTES);
    localparam logic [ACNT_W-1:0] ALAST = ACNT_W'(ADDR_BYTES - 1);
    localparam logic [ADDR_W-1:0] AONE  = ADDR_W'(1);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] ash;
        logic [ACNT_W-1:0] acnt;
        logic              fast;
        logic              is_wr;
        logic [7:0]        rbuf;
        logic              rpend;
        logic              drive;
        logic              wrote;
        logic              set_wen;
        logic              clr_wen;
        logic              sr_we;
        logic [7:0]        sr_wdata;
    } ctl_t;

    ctl_t c_q, c_d;
    logic [ADDR_W-1:0] addr_full;

    assign drive    = c_q.drive;
    assign set_wen  = c_q.set_wen;
    assign clr_wen  = c_q.clr_wen;
    assign sr_we    = c_q.sr_we;
    assign sr_wdata = c_q.sr_wdata;

    always_comb begin
        c_d          = c_q;
        c_d.set_wen  = 1'b0;
        c_d.clr_wen  = 1'b0;
        c_d.sr_we    = 1'b0;
        c_d.rpend    = 1'b0;
        mem_en       = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = c_q.addr;
        mem_wdata    = byte_val;
        addr_full    = ADDR_W'({c_q.ash, byte_val});

        if (c_q.rpend) begin
            c_d.rbuf = mem_rdata;
        end

        load_en  = (c_q.ph == PH_MEM_OUT) || (c_q.ph == PH_SR_OUT);
        load_val = (c_q.ph == PH_SR_OUT) ? status_i : c_q.rbuf;

        if (cs_fall) begin
            c_d.ph    = PH_OPCODE;
            c_d.acnt  = '0;
            c_d.ash   = '0;
            c_d.fast  = 1'b0;
            c_d.is_wr = 1'b0;
            c_d.drive = 1'b0;
            c_d.wrote = 1'b0;
        end else if (cs_rise) begin
            c_d.ph      = PH_DISCARD;
            c_d.drive   = 1'b0;
            c_d.wrote   = 1'b0;
            c_d.clr_wen = c_q.wrote;
        end else begin
            if (boundary && load_en) begin
                c_d.drive = 1'b1;
                if (c_q.ph == PH_MEM_OUT) begin
                    mem_en    = 1'b1;
                    mem_addr  = c_q.addr;
                    c_d.addr  = c_q.addr + AONE;
                    c_d.rpend = 1'b1;
                end
            end
            if (byte_done) begin
                unique case (c_q.ph)
                    PH_OPCODE: begin
                        unique case (byte_val)
                            OPC_RD:      c_d.ph = PH_ADDR;
                            OPC_RD_FAST: begin
                                c_d.ph   = PH_ADDR;
                                c_d.fast = 1'b1;
                            end
                            OPC_WR: begin
                                if (wen_i) begin
                                    c_d.ph    = PH_ADDR;
                                    c_d.is_wr = 1'b1;
                                    c_d.wrote = 1'b1;
                                end else begin
                                    c_d.ph = PH_DISCARD;
                                end
                            end
                            OPC_WEN_SET: begin
                                c_d.set_wen = 1'b1;
                                c_d.ph      = PH_DISCARD;
                            end
                            OPC_WEN_CLR: begin
                                c_d.clr_wen = 1'b1;
                                c_d.ph      = PH_DISCARD;
                            end
                            OPC_SR_RD:   c_d.ph = PH_SR_OUT;
                            OPC_SR_FAST: c_d.ph = PH_DUMMY_SR;
                            OPC_SR_WR: begin
                                if (wen_i) begin
                                    c_d.ph    = PH_SR_IN;
                                    c_d.wrote = 1'b1;
                                end else begin
                                    c_d.ph = PH_DISCARD;
                                end
                            end
                            default:     c_d.ph = PH_DISCARD;
                        endcase
                    end
                    PH_ADDR: begin
                        c_d.ash  = addr_full;
                        c_d.acnt = c_q.acnt + ACNT_W'(1);
                        if (c_q.acnt == ALAST) begin
                            if (c_q.is_wr) begin
                                c_d.addr = addr_full;
                                c_d.ph   = PH_MEM_IN;
                            end else begin
                                mem_en    = 1'b1;
                                mem_addr  = addr_full;
                                c_d.addr  = addr_full + AONE;
                                c_d.rpend = 1'b1;
                                c_d.ph    = c_q.fast ? PH_DUMMY_MEM : PH_MEM_OUT;
                            end
                        end
                    end
                    PH_DUMMY_MEM: c_d.ph = PH_MEM_OUT;
                    PH_DUMMY_SR:  c_d.ph = PH_SR_OUT;
                    PH_MEM_IN: begin
                        mem_en    = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = c_q.addr;
                        mem_wdata = byte_val;
                        c_d.addr  = c_q.addr + AONE;
                    end
                    PH_SR_IN: begin
                        c_d.sr_we    = 1'b1;
                        c_d.sr_wdata = byte_val;
                        c_d.ph       = PH_DISCARD;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.ph <= PH_DISCARD;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
    parameter int ADDR_W      = 17,
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic              wen_i,
    input  logic [7:0]        status_i,
    output logic              set_wen,
    output logic              clr_wen,
    output logic              sr_we,
    output logic [7:0]        sr_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    logic       sel, si_s, sck_lvl, hold_ok;
    logic       sck_rise, sck_fall, cs_fall, cs_rise;
    logic       byte_done, boundary, so_bit;
    logic [7:0] byte_val;
    logic       load_en, drive;
    logic [7:0] load_val;

    spi_mem_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .sel(sel), .si_s(si_s), .sck_lvl(sck_lvl), .hold_ok(hold_ok),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    spi_mem_bytes bytes_i (
        .clk(clk), .rst_n(rst_n),
        .start(cs_fall), .sck_lvl(sck_lvl),
        .rise(sck_rise), .fall(sck_fall), .si_s(si_s),
        .load_en(load_en), .load_val(load_val),
        .byte_done(byte_done), .byte_val(byte_val),
        .boundary(boundary), .so_bit(so_bit)
    );

    spi_mem_ctrl #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .byte_done(byte_done), .byte_val(byte_val), .boundary(boundary),
        .wen_i(wen_i), .status_i(status_i), .mem_rdata(mem_rdata),
        .load_en(load_en), .load_val(load_val), .drive(drive),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata),
        .set_wen(set_wen), .clr_wen(clr_wen),
        .sr_we(sr_we), .sr_wdata(sr_wdata)
    );

    assign so    = so_bit;
    assign so_oe = drive & hold_ok & sel;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic hold_n,
    input logic so_oe,
    input logic mem_en,
    input logic mem_we,
    input logic wen_i,
    input logic set_wen,
    input logic clr_wen,
    input logic sr_we
);
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe); // R8
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !mem_en); // R10
    AST_WRITE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen_i); // R4
    AST_WRITE_IS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en); // R2
    AST_SRWR_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> wen_i); // R7
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_wen, clr_wen, sr_we})); // R7
    AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_wen |=> !set_wen); // R7
    AST_HOLD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && $past(!hold_n) && $past(!hold_n, 2)) |-> !mem_en); // R9
endmodule

bind spi_mem_slave spi_mem_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
    .so_oe(so_oe), .mem_en(mem_en), .mem_we(mem_we), .wen_i(wen_i),
    .set_wen(set_wen), .clr_wen(clr_wen), .sr_we(sr_we)
);

// File: tb/spi_mem_slave_tb_top.sv
module spi_mem_slave_tb_top;
    localparam int AW    = 6;
    localparam int AB    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, set_wen, clr_wen, sr_we, mem_en, mem_we;
    logic [7:0] sr_wdata, mem_wdata, status_i;
    logic [7:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic wen_m;
    logic [7:0] sr_m;
    logic [7:0] mem_m [DEPTH];
    int en_cnt = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW), .ADDR_BYTES(AB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe), .wen_i(wen_m),
        .status_i(status_i), .set_wen(set_wen), .clr_wen(clr_wen),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_m[mem_addr] <= mem_wdata;
            mem_rdata <= mem_m[mem_addr];
            en_cnt <= en_cnt + 1;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_m <= 1'b0;
            sr_m  <= 8'h00;
        end else begin
            if (set_wen) wen_m <= 1'b1;
            if (clr_wen) wen_m <= 1'b0;
            if (sr_we)   sr_m  <= sr_wdata;
        end
    end
    assign status_i = {sr_m[7:2], wen_m, sr_m[0]};

    function automatic logic [7:0] pat(int a);
        return 8'(a * 37 + 11);
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = tx[i];
            wait_clk(HALF);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic put(input logic [7:0] tx);
        logic [7:0] d;
        xfer(tx, d);
    endtask

    task automatic sel_on(bit m3);
        sck = m3;
        wait_clk(6);
        cs_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic sel_off(bit m3);
        if (!m3) sck = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic cmd1(bit m3, logic [7:0] op);
        sel_on(m3);
        put(op);
        sel_off(m3);
    endtask

    task automatic send_addr(int a);
        put(8'hFF);
        put(8'hFF);
        put(8'hC0 | 8'(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int e0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R11 reset state
        chk("R11 so_oe", so_oe, 0);
        chk("R11 mem_en", mem_en, 0);
        chk("R11 pulses", {set_wen, clr_wen, sr_we}, 0);

        // R7 set latch
        cmd1(0, 8'h06);
        chk("R7 set", wen_m, 1);

        // R2 R3 full write burst from 5, wrapping, upper address bits set
        sel_on(0);
        put(8'h02);
        send_addr(5);
        for (int i = 0; i < DEPTH; i++) put(pat((5 + i) % DEPTH));
        sel_off(0);
        for (int a = 0; a < DEPTH; a++) chk("R2 R3 write", mem_m[a], pat(a));
        chk("R7 clear after write", wen_m, 0);

        // R4 write without enable
        e0 = en_cnt;
        sel_on(1);
        put(8'h02);
        send_addr(3);
        put(8'h00);
        put(8'h00);
        sel_off(1);
        chk("R4 no access", en_cnt - e0, 0);
        chk("R4 mem3", mem_m[3], pat(3));
        chk("R4 mem4", mem_m[4], pat(4));

        // R5 R3 read in mode 0 across the wrap; also shows next selection works (R4)
        sel_on(0);
        put(8'h03);
        send_addr(60);
        for (int i = 0; i < 8; i++) begin
            xfer(8'h00, r);
            chk("R5 R3 R4 read m0", r, pat((60 + i) % DEPTH));
        end
        chk("R1 so_oe during read", so_oe, 1);
        sel_off(0);
        chk("R8 so_oe after cs", so_oe, 0);

        // R1 full read in mode 3
        sel_on(1);
        put(8'h03);
        send_addr(0);
        for (int i = 0; i < DEPTH; i++) begin
            xfer(8'h00, r);
            chk("R1 read m3", r, pat(i));
        end
        sel_off(1);

        // R5 fast read in mode 3
        sel_on(1);
        put(8'h0B);
        send_addr(30);
        put(8'h00);
        for (int i = 0; i < 10; i++) begin
            xfer(8'h00, r);
            chk("R5 fast read", r, pat(30 + i));
        end
        sel_off(1);

        // R7 status write with enable
        cmd1(1, 8'h06);
        sel_on(1);
        put(8'h01);
        put(8'hB4);
        sel_off(1);
        chk("R7 status write", sr_m, 8'hB4);
        chk("R7 clear after sr write", wen_m, 0);

        // R7 status write without enable
        sel_on(0);
        put(8'h01);
        put(8'h3C);
        sel_off(0);
        chk("R7 guarded sr write", sr_m, 8'hB4);

        // R6 status reads
        sel_on(0);
        put(8'h05);
        xfer(8'h00, r);
        chk("R6 status rd1", r, 8'hB4);
        xfer(8'h00, r);
        chk("R6 status rd2", r, 8'hB4);
        sel_off(0);
        cmd1(0, 8'h06);
        sel_on(1);
        put(8'h09);
        put(8'h00);
        xfer(8'h00, r);
        chk("R6 fast status", r, 8'hB6);
        sel_off(1);

        // R7 clear latch
        cmd1(1, 8'h04);
        chk("R7 clear cmd", wen_m, 0);

        // R10 unknown opcode
        e0 = en_cnt;
        sel_on(0);
        put(8'hA7);
        put(8'h12);
        chk("R10 so_oe", so_oe, 0);
        put(8'h34);
        sel_off(0);
        chk("R10 no access", en_cnt - e0, 0);

        // R8 partial byte discarded
        cmd1(0, 8'h06);
        sel_on(0);
        put(8'h02);
        send_addr(10);
        put(8'h5A);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b0; si = 1'b1; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF);
        end
        sel_off(0);
        chk("R8 full byte", mem_m[10], 8'h5A);
        chk("R8 partial byte", mem_m[11], pat(11));

        // R9 hold pause
        cmd1(0, 8'h06);
        sel_on(0);
        put(8'h02);
        send_addr(20);
        put(8'h11);
        sck = 1'b0;
        wait_clk(HALF);
        hold_n = 1'b0;
        wait_clk(4);
        e0 = en_cnt;
        for (int i = 0; i < 5; i++) begin
            si = 1'b1;
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0; wait_clk(HALF);
        end
        chk("R9 no access in hold", en_cnt - e0, 0);
        hold_n = 1'b1;
        wait_clk(4);
        put(8'h22);
        sel_off(0);
        chk("R9 byte before", mem_m[20], 8'h11);
        chk("R9 byte after", mem_m[21], 8'h22);
        chk("R9 next untouched", mem_m[22], pat(22));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule